// File: doc/BRIEF.md
# Oversampled Phase-Frequency Detector with Forced Minimum Pulse

This block compares a reference clock and a feedback clock that are both slower than a fast system clock. It samples each of them through a synchronizer and keeps only their rising edges. The comparison state is held in two registered outputs, `up` and `dn`. A reference edge raises `up` and a feedback edge raises `dn`. Once both are high, a programmable counter holds them together for a while and then drops both at once. Because only edges matter, the duty cycle of either input does not change the result. The lock point is zero phase difference. When the input frequencies differ, the pulses that remain all have one sign, so the block also acts as a frequency detector.

The counter in the reset path sets a minimum width on both outputs. Even at exactly zero phase error, `up` and `dn` then give equal pulses of a known length rather than pulses too short to act on. Any edge that arrives while the two outputs are being held is stored, and it raises its output again just after they clear. A lock monitor compares how long `up` and `dn` stayed high in each reference interval. It raises `locked` after a programmable number of consecutive intervals in which the two high times differ by no more than one system clock.

Top module: `pfd_minpulse_top`

## Requirements
- R1: A rising edge on `ref_in` sets `up`. An input change first sampled at system clock edge k shows on the output at edge k+2. `up` then stays high until a reset of both outputs, whatever `ref_in` does in the meantime.
- R2: A rising edge on `fb_in` sets `dn` with the same latency as R1. `dn` stays high until a reset of both outputs.
- R3: `up` and `dn` clear only while both are high, and they always clear on the same edge. With delay setting D = `dly_cfg`, the time both are high together is exactly D+1 clocks. When the reference leads by L clocks, `up` is high for L+D+1 clocks and `dn` for D+1 clocks. When the feedback leads, the two widths are swapped.
- R4: At the boundary D = 0, the two outputs overlap for a single clock.
- R5: At the boundary D = 15 (the largest value of the default 4-bit setting), the two outputs overlap for 16 clocks.
- R6: An edge that arrives while both outputs are held high is remembered. Its output goes low for one clock when the hold ends, then rises again on the next edge.
- R7: Rising edges on both inputs in the same clock raise `up` and `dn` together. Both pulses are then D+1 clocks wide, so there is no dead zone at zero phase error.
- R8: The pulse widths depend only on the relative timing of the rising edges, not on how long either input stays high.
- R9: When the reference runs faster than the feedback, no cycle has `dn` high while `up` is low, and cycles with only `up` high do occur.
- R10: `locked` rises after `lock_cfg` consecutive reference intervals in which the high times of `up` and `dn` differ by at most one clock. The intervals are bounded by rising edges of the reference.
- R11: `locked` falls at the end of the first reference interval in which the high times of `up` and `dn` differ by more than one clock.
- R12: A synchronous active-high `rst` clears `up`, `dn`, the hold counter, the stored edges and `locked` by the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock that samples both inputs |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Reference clock, asynchronous to `clk` |
| fb_in | input | 1 | Feedback clock, asynchronous to `clk` |
| dly_cfg | input | DLY_W | Hold length D: both outputs stay high together for D+1 clocks |
| lock_cfg | input | LOCK_W | Number of matched reference intervals needed to assert `locked` |
| up | output | 1 | Registered pump-up request |
| dn | output | 1 | Registered pump-down request |
| locked | output | 1 | Lock indication |

## Verification
The bench uses the default parameters: two synchronizer stages, a 4-bit delay setting, an 8-bit lock count and a 10-bit high-time accumulator. With the 4-bit setting, both ends of the delay range, 0 and 15, can be reached and are checked for exact pulse widths. Lock thresholds and reference periods are kept short, so that acquiring lock and losing it both fit within a few hundred clocks. Both the phase-lead cases and the stored-edge case are checked as exact sequences of pulse widths, and these sequences are predicted from the edge timing alone.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

  // One bit per compared input: index of reference and feedback lanes
  localparam int LANE_REF = 0;
  localparam int LANE_FB  = 1;
  localparam int N_LANES  = 2;

  typedef struct packed {
    logic fb_rise;
    logic ref_rise;
  } pfd_edges_t;

  function automatic logic diff_le_one(input logic [15:0] a, input logic [15:0] b);
    logic [15:0] d;
    d = (a >= b) ? (a - b) : (b - a);
    return (d <= 16'd1);
  endfunction

endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  localparam int CHAIN = STAGES + 1;

  logic [CHAIN-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[CHAIN-2:0], din};
  end

  // Newest settled sample high, previous one low
  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/pfd_state_core.sv
module pfd_state_core #(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_rise,
  input  logic             fb_rise,
  input  logic [DLY_W-1:0] dly,
  output logic             up,
  output logic             dn
);
  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic             pr_q, pf_q, pr_d, pf_d;
  logic             up_d, dn_d;
  logic             both, expire;

  always_comb begin
    both   = up & dn;
    expire = both && (cnt_q == '0);
    cnt_d  = cnt_q;
    pr_d   = pr_q;
    pf_d   = pf_q;
    up_d   = up;
    dn_d   = dn;
    if (both) begin
      // hold phase: new edges are parked until the clear has happened
      pr_d = pr_q | ref_rise;
      pf_d = pf_q | fb_rise;
      if (expire) begin
        up_d = 1'b0;
        dn_d = 1'b0;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end else begin
      up_d = up | ref_rise | pr_q;
      dn_d = dn | fb_rise  | pf_q;
      pr_d = 1'b0;
      pf_d = 1'b0;
      if (up_d && dn_d) cnt_d = dly;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      up    <= 1'b0;
      dn    <= 1'b0;
      cnt_q <= '0;
      pr_q  <= 1'b0;
      pf_q  <= 1'b0;
    end else begin
      up    <= up_d;
      dn    <= dn_d;
      cnt_q <= cnt_d;
      pr_q  <= pr_d;
      pf_q  <= pf_d;
    end
  end
endmodule

// File: rtl/pfd_lock_mon.sv
module pfd_lock_mon #(
  parameter int HT_W   = 10,
  parameter int LOCK_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_rise,
  input  logic              up,
  input  logic              dn,
  input  logic [LOCK_W-1:0] lock_len,
  output logic              locked
);
  import pfd_pkg::*;

  localparam logic [HT_W-1:0]   HT_MAX   = {HT_W{1'b1}};
  localparam logic [LOCK_W-1:0] RUN_MAX  = {LOCK_W{1'b1}};

  logic [HT_W-1:0]   up_acc, dn_acc;
  logic [LOCK_W-1:0] run_q, run_inc;
  logic              match;

  always_comb begin
    match   = diff_le_one(16'(up_acc), 16'(dn_acc));
    run_inc = (run_q == RUN_MAX) ? run_q : run_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      up_acc <= '0;
      dn_acc <= '0;
      run_q  <= '0;
      locked <= 1'b0;
    end else if (ref_rise) begin
      // close the interval, start the next one with this cycle's sample
      up_acc <= HT_W'(up);
      dn_acc <= HT_W'(dn);
      if (match) begin
        run_q  <= run_inc;
        locked <= (run_inc >= lock_len);
      end else begin
        run_q  <= '0;
        locked <= 1'b0;
      end
    end else begin
      if (up && up_acc != HT_MAX) up_acc <= up_acc + 1'b1;
      if (dn && dn_acc != HT_MAX) dn_acc <= dn_acc + 1'b1;
    end
  end
endmodule

// File: rtl/pfd_minpulse_top.sv
module pfd_minpulse_top #(
  parameter int SYNC_STAGES = 2,
  parameter int DLY_W       = 4,
  parameter int LOCK_W      = 8,
  parameter int HT_W        = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_in,
  input  logic              fb_in,
  input  logic [DLY_W-1:0]  dly_cfg,
  input  logic [LOCK_W-1:0] lock_cfg,
  output logic              up,
  output logic              dn,
  output logic              locked
);
  import pfd_pkg::*;

  logic [N_LANES-1:0] raw_in;
  logic [N_LANES-1:0] rise_v;
  pfd_edges_t         edges;

  assign raw_in[LANE_REF] = ref_in;
  assign raw_in[LANE_FB]  = fb_in;

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    pfd_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk  (clk),
      .rst  (rst),
      .din  (raw_in[g]),
      .rise (rise_v[g])
    );
  end

  assign edges.ref_rise = rise_v[LANE_REF];
  assign edges.fb_rise  = rise_v[LANE_FB];

  pfd_state_core #(.DLY_W(DLY_W)) core_i (
    .clk      (clk),
    .rst      (rst),
    .ref_rise (edges.ref_rise),
    .fb_rise  (edges.fb_rise),
    .dly      (dly_cfg),
    .up       (up),
    .dn       (dn)
  );

  pfd_lock_mon #(.HT_W(HT_W), .LOCK_W(LOCK_W)) lock_i (
    .clk      (clk),
    .rst      (rst),
    .ref_rise (edges.ref_rise),
    .up       (up),
    .dn       (dn),
    .lock_len (lock_cfg),
    .locked   (locked)
  );
endmodule

// File: rtl/pfd_minpulse_chk.sv
module pfd_minpulse_chk #(
  parameter int DLY_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [DLY_W-1:0] dly_cfg,
  input logic             up,
  input logic             dn,
  input logic             locked
);
  logic [DLY_W:0] ovl_q;

  always_ff @(posedge clk) begin
    if (rst)           ovl_q <= '0;
    else if (up && dn) ovl_q <= ovl_q + 1'b1;
    else               ovl_q <= '0;
  end

  // R3: a held pair leaves together
  assert_clear_together_R3: assert property (@(posedge clk) disable iff (rst)
    (up && dn) |=> (up == dn));

  // R3: up only drops out of the both-high state
  assert_up_fall_needs_dn_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(up) |-> $past(dn));

  // R3: dn only drops out of the both-high state
  assert_dn_fall_needs_up_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(dn) |-> $past(up));

  // R3: overlap length equals setting plus one
  assert_overlap_len_R3: assert property (@(posedge clk) disable iff (rst)
    ($fell(up) && $stable(dly_cfg)) |-> (ovl_q == {1'b0, $past(dly_cfg)} + 1'b1));

  // R12: reset clears every output
  assert_reset_clears_R12: assert property (@(posedge clk)
    rst |=> (!up && !dn && !locked));
endmodule

bind pfd_minpulse_top pfd_minpulse_chk #(.DLY_W(DLY_W)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .dly_cfg (dly_cfg),
  .up      (up),
  .dn      (dn),
  .locked  (locked)
);

// File: tb/pfd_minpulse_tb.sv
`timescale 1ns/1ps
module pfd_minpulse_top_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ref_in = 1'b0;
  logic       fb_in = 1'b0;
  logic [3:0] dly_cfg = 4'd3;
  logic [7:0] lock_cfg = 8'd3;
  logic       up, dn, locked;

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit sb_on = 0;
  int q_up[$];
  int q_dn[$];
  int up_w = 0;
  int dn_w = 0;
  bit up_p = 0;
  bit dn_p = 0;
  int up_only = 0;
  int dn_only = 0;
  bit win_on = 0;

  always #5 clk = ~clk;

  pfd_minpulse_top dut_i (
    .clk(clk), .rst(rst), .ref_in(ref_in), .fb_in(fb_in),
    .dly_cfg(dly_cfg), .lock_cfg(lock_cfg),
    .up(up), .dn(dn), .locked(locked)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: measures each finished pulse and pops the expected width
  always @(negedge clk) begin
    if (win_on) begin
      if (up && !dn) up_only++;
      if (dn && !up) dn_only++;
    end
    if (up) up_w++;
    if (dn) dn_w++;
    if (!up && up_p) begin
      if (sb_on) begin
        if (q_up.size() == 0) check("R3 up pulse (unexpected)", up_w, -1);
        else check("R3 up width", up_w, q_up.pop_front());
      end
      up_w = 0;
    end
    if (!dn && dn_p) begin
      if (sb_on) begin
        if (q_dn.size() == 0) check("R3 dn pulse (unexpected)", dn_w, -1);
        else check("R3 dn width", dn_w, q_dn.pop_front());
      end
      dn_w = 0;
    end
    up_p = up;
    dn_p = dn;
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // off >= 0: reference leads by off clocks; off < 0: feedback leads
  task automatic pair(input int off, input int rhi, input int fhi);
    int rs, fs, len, d;
    rs  = (off >= 0) ? 0 : -off;
    fs  = (off >= 0) ? off : 0;
    d   = int'(dly_cfg);
    len = rs + fs + rhi + fhi + 2;
    q_up.push_back(((off >= 0) ? off : 0) + d + 1);
    q_dn.push_back(((off < 0) ? -off : 0) + d + 1);
    for (int c = 0; c < len; c++) begin
      ref_in = (c >= rs && c < rs + rhi);
      fb_in  = (c >= fs && c < fs + fhi);
      cyc(1);
    end
    ref_in = 0;
    fb_in  = 0;
    cyc(40);
  endtask

  task automatic check_drained(input string req);
    check({req, " pending up items"}, q_up.size(), 0);
    check({req, " pending dn items"}, q_dn.size(), 0);
    q_up.delete();
    q_dn.delete();
  endtask

  task automatic periodic(input int period, input int fb_off, input int n);
    for (int c = 0; c < period * n; c++) begin
      ref_in = ((c % period) < period / 2);
      fb_in  = (((c + period - fb_off) % period) < period / 2);
      cyc(1);
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst = 0;
    cyc(2);
    // R12: reset state
    check("R12 up after reset", up, 0);
    check("R12 dn after reset", dn, 0);
    check("R12 locked after reset", locked, 0);

    sb_on = 1;
    dly_cfg = 4'd3;
    pair(5, 10, 10);   // R1: reference leads, up = 5+4, dn = 4
    pair(-6, 10, 10);  // R2: feedback leads, dn = 6+4, up = 4
    pair(0, 8, 8);     // R7: same-cycle edges, both 4
    pair(2, 2, 20);    // R8: short reference high time
    pair(2, 15, 3);    // R8: long reference high time, same widths
    dly_cfg = 4'd0;
    cyc(2);
    pair(3, 6, 6);     // R4: overlap of one clock
    pair(0, 6, 6);     // R4
    dly_cfg = 4'd15;
    cyc(2);
    pair(4, 6, 6);     // R5: overlap of sixteen clocks
    pair(-1, 6, 6);    // R5
    check_drained("R3");

    // R6: reference edge parked during the hold of a D=8 overlap
    dly_cfg = 4'd8;
    cyc(2);
    q_up.push_back(9);
    q_up.push_back(29);
    q_dn.push_back(9);
    q_dn.push_back(9);
    for (int c = 0; c < 60; c++) begin
      ref_in = (c < 2) || (c >= 4 && c < 8);
      fb_in  = (c < 2) || (c >= 30 && c < 34);
      cyc(1);
    end
    ref_in = 0;
    fb_in = 0;
    cyc(30);
    check_drained("R6");
    sb_on = 0;

    // R9: reference faster than feedback
    rst = 1;
    dly_cfg = 4'd2;
    cyc(2);
    rst = 0;
    cyc(2);
    fork
      begin
        for (int c = 0; c < 300; c++) begin
          ref_in = ((c % 10) < 5);
          fb_in  = ((c % 25) < 12);
          if (c == 60) win_on = 1;
          cyc(1);
        end
      end
    join
    win_on = 0;
    ref_in = 0;
    fb_in = 0;
    check("R9 dn-only cycles", dn_only, 0);
    check("R9 up-only cycles seen", (up_only > 0) ? 1 : 0, 1);
    cyc(40);

    // R10 / R11: lock acquisition and loss
    rst = 1;
    lock_cfg = 8'd3;
    cyc(2);
    rst = 0;
    cyc(1);
    periodic(20, 0, 1);
    cyc(0);
    check("R10 not locked after one interval", locked, 0);
    periodic(20, 0, 5);
    check("R10 locked after matched intervals", locked, 1);
    periodic(20, 4, 3);
    check("R11 lock lost on mismatch", locked, 0);
    periodic(20, 0, 5);
    check("R10 relocked", locked, 1);
    rst = 1;
    cyc(1);
    rst = 0;
    #2;
    check("R12 locked cleared by reset", locked, 0);
    check("R12 up cleared by reset", up, 0);
    check("R12 dn cleared by reset", dn, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule